// File: doc/BRIEF.md
# UART Interrupt Prioritizer and Identifier

This block merges the four interrupt causes of a UART into one interrupt request and an 8-bit identification value that names the most urgent enabled cause. The causes, from most to least urgent, are a receive line error, a received character waiting, an empty transmit holding register, and a modem input change. Each cause keeps its own pending flag. A single-cycle event pulse from the surrounding UART logic sets that flag, and the register access that services the cause clears it.

The host side gives the block one cycle-wide strobe per access: reading the line status register, the receive buffer, the identification value and the modem status register, and writing the transmit holding register. The transmit-empty cause differs from the others. The block arms it on its own when the holding register becomes empty, or when that cause is enabled while the register is already empty. Reading the identification value clears it only if it is the cause being reported at that moment.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, `iir` reads 8'h01 and `irq` is low.
- R2: `iir[7:3]` is always zero. `iir[0]` is 0 exactly when an enabled cause is pending, and `irq` is always the inverse of `iir[0]`.
- R3: The causes rank in this order: line error first, received data second, transmit empty third, modem change fourth. Bits `iir[2:1]` identify the highest enabled pending cause with the codes 2'b11, 2'b10, 2'b01 and 2'b00 respectively.
- R4: The enable bits map as follows: `ien[0]` received data, `ien[1]` transmit empty, `ien[2]` line error, `ien[3]` modem change. A disabled cause keeps its pending flag. Enabling it makes the flag visible on `iir` and `irq` in the same cycle.
- R5: A pulse on `ls_evt` makes the line-error cause pending from the next cycle. A `rd_lsr` strobe clears it from the next cycle.
- R6: A pulse on `rx_evt` makes the received-data cause pending from the next cycle. A `rd_rbr` strobe clears it from the next cycle.
- R7: A `wr_thr` strobe clears the transmit-empty cause. A `rd_iir` strobe clears it only when `iir[2:0]` shows 3'b010 in that cycle. A `rd_iir` strobe while another cause is reported leaves it pending.
- R8: The transmit-empty cause becomes pending in the cycle after `thr_empty` rises, or in the cycle after `ien[1]` rises while `thr_empty` is high.
- R9: A pulse on `ms_evt` makes the modem-change cause pending from the next cycle. A `rd_msr` strobe clears it from the next cycle.
- R10: When a cause's set event and its clearing strobe arrive in the same cycle, the cause stays pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ien | input | 4 | Per-cause enable bits (mapping in R4) |
| ls_evt | input | 1 | Line error (overrun, parity, framing, break) event pulse |
| rx_evt | input | 1 | Received character loaded event pulse |
| thr_empty | input | 1 | Transmit holding register empty level |
| ms_evt | input | 1 | Modem input change event pulse |
| rd_lsr | input | 1 | Line status register read strobe |
| rd_rbr | input | 1 | Receive buffer read strobe |
| rd_iir | input | 1 | Identification value read strobe |
| rd_msr | input | 1 | Modem status register read strobe |
| wr_thr | input | 1 | Transmit holding register write strobe |
| irq | output | 1 | Interrupt request, high while an enabled cause is pending |
| iir | output | 8 | Identification value |

## Verification
Event pulses and clearing strobes act through one register stage, so their effect on `iir` and `irq` is due one clock edge after the cycle in which they are driven. Enable changes reach the outputs in the same cycle. A transmit-empty arm caused by a rising level or a rising enable also appears one edge later. The bench drives every input just after the falling edge, compares the outputs 1 ns later against a model advanced once per cycle, and then folds that cycle's inputs into the model for the next comparison. Both latencies are therefore checked at the exact cycle they are due.

// File: rtl/uart_irq_pkg.sv
// Package: shared constants and helpers for the UART interrupt identifier.
// Assumes cause index 0 is the most urgent and index NSRC-1 the least.
package uart_irq_pkg;

    localparam int NSRC  = 4;
    localparam int IDX_W = $clog2(NSRC);

    // Cause indices in priority order
    localparam int SRC_LINE = 0;
    localparam int SRC_RXD  = 1;
    localparam int SRC_THRE = 2;
    localparam int SRC_MDM  = 3;

    // Three low identification bits, bit 0 = 0 means pending
    localparam logic [2:0] ID_NONE = 3'b001;
    localparam logic [2:0] ID_LINE = 3'b110;
    localparam logic [2:0] ID_RXD  = 3'b100;
    localparam logic [2:0] ID_THRE = 3'b010;
    localparam logic [2:0] ID_MDM  = 3'b000;

    // Maps a cause index to its identification code
    function automatic logic [2:0] id_code(input logic [IDX_W-1:0] idx);
        case (idx)
            IDX_W'(SRC_LINE): id_code = ID_LINE;
            IDX_W'(SRC_RXD):  id_code = ID_RXD;
            IDX_W'(SRC_THRE): id_code = ID_THRE;
            default:          id_code = ID_MDM;
        endcase
    endfunction

endpackage

// File: rtl/uart_irq_latch.sv
// Module: bank of pending flags, one per interrupt cause.
// Assumes set and clear are single-cycle strobes. Set wins over clear so an
// event arriving during its own service access is not lost.
module uart_irq_latch #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);

    for (genvar g = 0; g < N; g++) begin : g_flag
        // Holds one cause pending from its event until its service strobe
        always_ff @(posedge clk) begin
            if (!rst_n)      pend[g] <= 1'b0;
            else if (set[g]) pend[g] <= 1'b1;
            else if (clr[g]) pend[g] <= 1'b0;
        end
    end

endmodule

// File: rtl/uart_irq_thre_arm.sv
// Module: produces the arming pulse for the transmit-empty cause.
// Assumes thr_empty is a level that is high while the holding register is
// empty. Arms on a rising empty level, or on a rising enable while empty.
module uart_irq_thre_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic thr_empty,
    input  logic thre_en,
    output logic arm
);

    logic empty_q;
    logic en_q;

    // Remembers last cycle's empty level and enable for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty_q <= 1'b1;
            en_q    <= 1'b0;
        end else begin
            empty_q <= thr_empty;
            en_q    <= thre_en;
        end
    end

    // Arms when empty appears or the cause is switched on while empty
    always_comb begin
        arm = thr_empty & (~empty_q | (thre_en & ~en_q));
    end

endmodule

// File: rtl/uart_irq_prio.sv
// Module: fixed-priority encoder turning enabled pending flags into the
// identification value and the interrupt request.
// Assumes index 0 is the most urgent cause.
module uart_irq_prio
    import uart_irq_pkg::*;
#(
    parameter int N     = NSRC,
    parameter int IIR_W = 8
) (
    input  logic [N-1:0]     pend,
    input  logic [N-1:0]     en,
    output logic [IIR_W-1:0] iir,
    output logic             irq,
    output logic             thre_shown
);

    localparam int SEL_W = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]     live;
    logic [SEL_W-1:0] sel;
    logic             hit;
    logic [2:0]       code;

    // Masks pending flags with their enables
    always_comb begin
        live = pend & en;
    end

    // Scans from least to most urgent so the most urgent cause wins
    always_comb begin
        sel = '0;
        hit = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (live[i]) begin
                sel = SEL_W'(i);
                hit = 1'b1;
            end
        end
    end

    // Builds the identification value and request from the winner
    always_comb begin
        code       = hit ? id_code(IDX_W'(sel)) : ID_NONE;
        iir        = {{(IIR_W-3){1'b0}}, code};
        irq        = hit;
        thre_shown = hit && (sel == SEL_W'(SRC_THRE));
    end

endmodule

// File: rtl/uart_irq_ident.sv
// Module: top of the UART interrupt identifier. It routes event pulses and
// service strobes to the pending flags, arms the transmit-empty cause, and
// reports the highest enabled pending cause.
// Assumes all inputs are synchronous to clk and strobes last one cycle.
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int IIR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       ien,
    input  logic             ls_evt,
    input  logic             rx_evt,
    input  logic             thr_empty,
    input  logic             ms_evt,
    input  logic             rd_lsr,
    input  logic             rd_rbr,
    input  logic             rd_iir,
    input  logic             rd_msr,
    input  logic             wr_thr,
    output logic             irq,
    output logic [IIR_W-1:0] iir
);

    logic [NSRC-1:0] en_src;
    logic [NSRC-1:0] set_src;
    logic [NSRC-1:0] clr_src;
    logic [NSRC-1:0] pend_q;
    logic            thre_arm;
    logic            thre_shown;

    // Reorders enable bits from register layout into priority order
    always_comb begin
        en_src[SRC_LINE] = ien[2];
        en_src[SRC_RXD]  = ien[0];
        en_src[SRC_THRE] = ien[1];
        en_src[SRC_MDM]  = ien[3];
    end

    // Collects the set events of each cause
    always_comb begin
        set_src[SRC_LINE] = ls_evt;
        set_src[SRC_RXD]  = rx_evt;
        set_src[SRC_THRE] = thre_arm;
        set_src[SRC_MDM]  = ms_evt;
    end

    // Collects the service strobes of each cause
    always_comb begin
        clr_src[SRC_LINE] = rd_lsr;
        clr_src[SRC_RXD]  = rd_rbr;
        clr_src[SRC_THRE] = wr_thr | (rd_iir & thre_shown);
        clr_src[SRC_MDM]  = rd_msr;
    end

    uart_irq_thre_arm i_arm (
        .clk       (clk),
        .rst_n     (rst_n),
        .thr_empty (thr_empty),
        .thre_en   (ien[1]),
        .arm       (thre_arm)
    );

    uart_irq_latch #(.N(NSRC)) i_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (set_src),
        .clr   (clr_src),
        .pend  (pend_q)
    );

    uart_irq_prio #(.N(NSRC), .IIR_W(IIR_W)) i_prio (
        .pend       (pend_q),
        .en         (en_src),
        .iir        (iir),
        .irq        (irq),
        .thre_shown (thre_shown)
    );

endmodule

// File: rtl/uart_irq_ident_chk.sv
// Module: property checker for uart_irq_ident, attached by bind.
// Assumes the default 8-bit identification width.
module uart_irq_ident_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] ien,
    input logic       ls_evt,
    input logic       thr_empty,
    input logic       ms_evt,
    input logic       rd_lsr,
    input logic       rd_msr,
    input logic       wr_thr,
    input logic       irq,
    input logic [7:0] iir,
    input logic [3:0] pend_q
);

    assert_high_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        iir[7:3] == 5'b0);

    assert_irq_vs_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ~iir[0]);

    assert_line_code_backed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (iir[2:0] == 3'b110) |-> (pend_q[0] && ien[2]));

    assert_line_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ls_evt |=> pend_q[0]);

    assert_line_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lsr && !ls_evt) |=> !pend_q[0]);

    assert_thre_write_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_thr && !thr_empty) |=> !pend_q[2]);

    assert_modem_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_msr && !ms_evt) |=> !pend_q[3]);

    assert_modem_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_evt && rd_msr) |=> pend_q[3]);

endmodule

bind uart_irq_ident uart_irq_ident_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ien       (ien),
    .ls_evt    (ls_evt),
    .thr_empty (thr_empty),
    .ms_evt    (ms_evt),
    .rd_lsr    (rd_lsr),
    .rd_msr    (rd_msr),
    .wr_thr    (wr_thr),
    .irq       (irq),
    .iir       (iir),
    .pend_q    (pend_q)
);

// File: tb/test_uart_irq_ident.sv
`timescale 1ns/1ps
module test_uart_irq_ident;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ien = 4'h0;
    logic       ls_evt = 1'b0, rx_evt = 1'b0, thr_empty = 1'b1, ms_evt = 1'b0;
    logic       rd_lsr = 1'b0, rd_rbr = 1'b0, rd_iir = 1'b0, rd_msr = 1'b0, wr_thr = 1'b0;
    logic       irq;
    logic [7:0] iir;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Model state: index 0 line, 1 rx data, 2 thre, 3 modem
    logic [3:0] m_pend = 4'h0;
    logic       m_te_q = 1'b1;
    logic       m_en_q = 1'b0;

    always #10 clk = ~clk;

    uart_irq_ident i_uart_irq_ident (
        .clk(clk), .rst_n(rst_n), .ien(ien),
        .ls_evt(ls_evt), .rx_evt(rx_evt), .thr_empty(thr_empty), .ms_evt(ms_evt),
        .rd_lsr(rd_lsr), .rd_rbr(rd_rbr), .rd_iir(rd_iir), .rd_msr(rd_msr),
        .wr_thr(wr_thr), .irq(irq), .iir(iir)
    );

    // Expected identification value from the requirements
    function automatic logic [7:0] exp_iir(input logic [3:0] p, input logic [3:0] e);
        logic [3:0] live;
        live = p & {e[3], e[1], e[0], e[2]};
        if (live[0])      return 8'h06;
        else if (live[1]) return 8'h04;
        else if (live[2]) return 8'h02;
        else if (live[3]) return 8'h00;
        else              return 8'h01;
    endfunction

    task automatic check(input string tag);
        logic [7:0] ei;
        ei = exp_iir(m_pend, ien);
        n_vec++;
        if (iir !== ei || irq !== ~ei[0]) begin
            n_bad++;
            $display("FAIL %s: iir=%h irq=%b expected iir=%h irq=%b", tag, iir, irq, ei, ~ei[0]);
        end
    endtask

    // Advances the model by the edge that follows the current inputs
    task automatic model_step();
        logic       shown, arm;
        logic [3:0] s, c;
        shown = (exp_iir(m_pend, ien) == 8'h02);
        arm   = thr_empty & (~m_te_q | (ien[1] & ~m_en_q));
        s = {ms_evt, arm, rx_evt, ls_evt};
        c = {rd_msr, wr_thr | (rd_iir & shown), rd_rbr, rd_lsr};
        for (int i = 0; i < 4; i++)
            if (s[i]) m_pend[i] = 1'b1;
            else if (c[i]) m_pend[i] = 1'b0;
        m_te_q = thr_empty;
        m_en_q = ien[1];
    endtask

    // One cycle: drive after the falling edge, compare, then update the model
    task automatic cyc(input logic [3:0] e, input logic te,
                       input logic ls, input logic rx, input logic ms,
                       input logic rl, input logic rr, input logic ri,
                       input logic rm, input logic wt, input string tag);
        @(negedge clk);
        ien = e; thr_empty = te; ls_evt = ls; rx_evt = rx; ms_evt = ms;
        rd_lsr = rl; rd_rbr = rr; rd_iir = ri; rd_msr = rm; wr_thr = wt;
        #1;
        check(tag);
        model_step();
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd2024;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        cyc(4'h0, 1, 0,0,0, 0,0,0,0,0, "R1 reset");
        // R4 disabled cause latched, visible when enabled
        cyc(4'h0, 1, 1,0,0, 0,0,0,0,0, "R4 event while disabled");
        cyc(4'h0, 1, 0,0,0, 0,0,0,0,0, "R4 stays hidden");
        cyc(4'h4, 1, 0,0,0, 0,0,0,0,0, "R4 enable reveals");
        // R5 clear by line status read
        cyc(4'h4, 1, 0,0,0, 1,0,0,0,0, "R5 read strobe cycle");
        cyc(4'h4, 1, 0,0,0, 0,0,0,0,0, "R5 cleared");
        // R6 and R3 priority
        cyc(4'h5, 1, 0,1,0, 0,0,0,0,0, "R6 rx event");
        cyc(4'h5, 1, 1,0,0, 0,0,0,0,0, "R6 rx pending");
        cyc(4'h5, 1, 0,0,0, 0,0,0,0,0, "R3 line over rx");
        cyc(4'h5, 1, 0,0,0, 1,0,0,0,0, "R3 rx after line");
        cyc(4'h5, 1, 0,0,0, 0,1,0,0,0, "R6 rbr read");
        cyc(4'h5, 1, 0,0,0, 0,0,0,0,0, "R6 cleared");
        // R8 enable while empty arms transmit empty
        cyc(4'h7, 1, 0,0,0, 0,0,0,0,0, "R8 enable while empty");
        cyc(4'h7, 1, 1,0,0, 0,0,0,0,0, "R8 armed");
        cyc(4'h7, 1, 0,0,0, 0,0,1,0,0, "R7 id read under line");
        cyc(4'h7, 1, 0,0,0, 1,0,0,0,0, "R7 thre survives");
        cyc(4'h7, 1, 0,0,0, 0,0,1,0,0, "R7 thre reported");
        cyc(4'h7, 1, 0,0,0, 0,0,0,0,0, "R7 id read cleared");
        // R8 rising empty after write, R7 write clears
        cyc(4'h7, 0, 0,0,0, 0,0,0,0,1, "R7 write");
        cyc(4'h7, 0, 0,0,0, 0,0,0,0,0, "R7 still clear");
        cyc(4'h7, 1, 0,0,0, 0,0,0,0,0, "R8 empty rises");
        cyc(4'h7, 0, 0,0,0, 0,0,0,0,1, "R8 rearmed");
        cyc(4'hF, 0, 0,0,0, 0,0,0,0,0, "R7 write cleared");
        // R9 modem, R10 set beats clear
        cyc(4'hF, 0, 0,0,1, 0,0,0,0,0, "R9 modem event");
        cyc(4'hF, 0, 0,0,1, 0,0,0,1,0, "R9 modem pending");
        cyc(4'hF, 0, 0,0,0, 0,0,0,0,0, "R10 set with read");
        cyc(4'hF, 0, 0,0,0, 0,0,0,1,0, "R10 kept");
        cyc(4'hF, 0, 0,0,0, 0,0,0,0,0, "R9 cleared");

        // Random mix checked against the model (R2/R3/R4 in every vector)
        for (int k = 0; k < 3000; k++) begin
            logic [15:0] r;
            r = 16'($urandom);
            cyc(r[3:0], ($urandom % 4) != 0,
                ($urandom % 6) == 0, ($urandom % 5) == 0, ($urandom % 6) == 0,
                ($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 3) == 0,
                ($urandom % 4) == 0, ($urandom % 5) == 0, "R2/R3/R4 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule